// File: doc/BRIEF.md
# LRCK Synchronization Monitor

This block sits in the PLL clock domain of an audio input path. It checks that the incoming frame clock (LRCK) stays locked in frequency to the PLL output. It does this by counting PLL cycles between successive LRCK rising edges and comparing the count with an expected ratio `ratio_n`, within a tolerance of four cycles. It also watches the PLL lock indicator. A period outside the window, a missing LRCK edge, or a loss of lock is a fault.

When detection is enabled, a fault raises `mute` at once. `mute` silences the PCM samples sent to processing. The same fault raises `freeze`, which halts any processing task that is running. Both outputs stay high until the stream has been healthy for a run of consecutive in-range periods. A sticky flag records that a fault has happened, whatever the enable setting, and stays set until it is cleared.

Top module: `lrck_sync_monitor`

## Requirements
- R1: After reset, `mute`, `freeze` and `fault_seen` are all low.
- R2: LRCK is sampled through a two-stage synchronizer. A period is the number of clock cycles between two successive synchronized rising edges. The period is in range when it lies between `ratio_n`-4 and `ratio_n`+4, both bounds included (the lower bound stops at 0). The first rising edge after reset only starts a measurement.
- R3: When `detect_en` is 1, a measured period outside the range asserts `mute` within four clock cycles of the LRCK rising edge that ends that period.
- R4: If no rising edge arrives while the period count climbs past `ratio_n`+4, a fault is raised while the edge is still missing. The count then holds at `ratio_n`+5.
- R5: When `detect_en` is 1, a low `pll_locked` asserts `mute` on the next clock edge.
- R6: After a fault, `mute` falls only after 4 consecutive in-range periods with the PLL locked. Any fault in between restarts this run.
- R7: While `detect_en` is 0, no fault asserts `mute` or `freeze`. Clearing `detect_en` releases both on the next clock edge.
- R8: `fault_seen` goes high on any fault, whatever the value of `detect_en`. It stays high until `status_clr` is pulsed in a cycle with no fault. A fault in the same cycle as the clear wins.
- R9: `freeze` always equals `mute`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck_in | input | 1 | Asynchronous frame clock |
| pll_locked | input | 1 | PLL lock indicator, synchronous to `clk` |
| detect_en | input | 1 | Enables mute and freeze on a fault |
| ratio_n | input | CNT_W | Expected clock cycles per LRCK period |
| status_clr | input | 1 | Clears `fault_seen` |
| mute | output | 1 | Mutes PCM data going to processing |
| freeze | output | 1 | Freezes active processing |
| fault_seen | output | 1 | Sticky fault record |

## Verification
The bench builds the block with an 8-bit counter (`CNT_W` = 8), a tolerance of 4 and a recovery run of 4, and drives `ratio_n` = 64. A 64-cycle frame and a timeout at 69 cycles keep every fault and every recovery run to a few hundred clock cycles. This makes the exact window edges (60, 68, 59, 69), a full four-period release and a timeout with LRCK stopped all cheap to reach. The 8-bit width also shows that the saturation value `ratio_n`+5 fits without wrapping.

// File: rtl/lrck_mon_pkg.sv
// Package: types shared by the LRCK synchronization monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package lrck_mon_pkg;

    // Result of one period measurement, valid for a single cycle
    typedef struct packed {
        logic ok;   // a finished period fell inside the window
        logic bad;  // a finished period fell outside it, or the edge is overdue
    } verdict_t;

endpackage

// File: rtl/lrck_edge_sync.sv
// Module: lrck_edge_sync
// Brings the asynchronous frame clock into the clk domain through STAGES
// flip-flops. Gives a one-cycle pulse on each synchronized rising edge.
// Assumes: STAGES >= 2; lrck_in is held for several clk cycles per level.
module lrck_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    // synchronizer chain plus one history bit for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], lrck_in};
    end

    // rising edge is seen at the last synchronizer stage
    always_comb rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R2: an edge pulse never lasts longer than one cycle
    p_rise_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/lrck_period_check.sv
// Module: lrck_period_check
// Counts clk cycles between synchronized LRCK rising edges. Judges each
// finished period against ratio_n +/- TOL. Flags a timeout when the count
// runs past the upper bound, then saturates one above it.
// Assumes: ratio_n is static while the stream is being measured.
module lrck_period_check
    import lrck_mon_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TOL   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [CNT_W-1:0] ratio_n,
    output verdict_t         verdict
);
    localparam int          W     = CNT_W + 1;
    localparam logic [W-1:0] TOL_V = W'(TOL);

    logic [W-1:0] cnt_q, n_ext, lo_b, hi_b, sat_v;
    logic         armed_q, in_win;

    // window bounds; lower bound clamps at zero for small ratios
    always_comb begin
        n_ext = {1'b0, ratio_n};
        hi_b  = n_ext + TOL_V;
        lo_b  = (n_ext > TOL_V) ? n_ext - TOL_V : '0;
        sat_v = hi_b + W'(1);
    end

    // period counter: restart at an edge, otherwise climb to saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (rise) begin
            cnt_q   <= W'(1);
            armed_q <= 1'b1;
        end else if (cnt_q < sat_v) begin
            cnt_q   <= cnt_q + W'(1);
        end
    end

    // verdict: judged at an edge once armed, or timeout on the last legal count
    always_comb begin
        in_win      = (cnt_q >= lo_b) && (cnt_q <= hi_b);
        verdict.ok  = rise && armed_q && in_win;
        verdict.bad = (rise && armed_q && !in_win) || (!rise && cnt_q == hi_b);
    end

    // R2: every edge restarts the measurement at one
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> cnt_q == W'(1));
    // R4: with no edge, a saturated count stays put
    p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && cnt_q >= sat_v) |=> $stable(cnt_q));
endmodule

// File: rtl/lrck_fault_ctrl.sv
// Module: lrck_fault_ctrl
// Turns period verdicts and PLL lock into the mute state and a sticky
// fault record. Release needs GOOD_RUN consecutive good periods.
// Assumes: pll_locked is already synchronous to clk.
module lrck_fault_ctrl
    import lrck_mon_pkg::*;
#(
    parameter int GOOD_RUN = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_t verdict,
    input  logic     pll_locked,
    input  logic     detect_en,
    input  logic     status_clr,
    output logic     muted,
    output logic     fault_seen
);
    localparam int GW = $clog2(GOOD_RUN + 1);

    logic          fault_now;
    logic [GW-1:0] good_q;
    logic          muted_q, seen_q;

    // any fault condition in this cycle
    always_comb fault_now = verdict.bad | ~pll_locked;

    // mute state and recovery run counter
    always_ff @(posedge clk) begin
        if (!rst_n || !detect_en) begin
            muted_q <= 1'b0;
            good_q  <= '0;
        end else if (fault_now) begin
            muted_q <= 1'b1;
            good_q  <= '0;
        end else if (muted_q && verdict.ok) begin
            if (good_q == GW'(GOOD_RUN - 1)) begin
                muted_q <= 1'b0;
                good_q  <= '0;
            end else begin
                good_q  <= good_q + GW'(1);
            end
        end
    end

    // sticky record: a fault wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          seen_q <= 1'b0;
        else if (fault_now)  seen_q <= 1'b1;
        else if (status_clr) seen_q <= 1'b0;
    end

    assign muted      = muted_q;
    assign fault_seen = seen_q;

    // R3 R5: an enabled fault mutes on the next edge
    p_fault_mutes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_en && fault_now) |=> muted_q);
    // R7: a cleared enable releases the mute
    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !detect_en |=> !muted_q);
    // R6: mute only falls on a good period or a cleared enable
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(muted_q) |-> ($past(verdict.ok) || !$past(detect_en)));
    // R8: the record holds until a clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !status_clr) |=> seen_q);
endmodule

// File: rtl/lrck_sync_monitor.sv
// Module: lrck_sync_monitor (top)
// Checks that LRCK runs at clk/ratio_n within +/-TOL cycles and that the
// PLL is locked. Mutes the PCM path and freezes processing on a fault
// while detection is enabled.
// Assumes: clk is the PLL output; pll_locked is synchronous to clk.
module lrck_sync_monitor
    import lrck_mon_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int TOL         = 4,
    parameter int GOOD_RUN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrck_in,
    input  logic             pll_locked,
    input  logic             detect_en,
    input  logic [CNT_W-1:0] ratio_n,
    input  logic             status_clr,
    output logic             mute,
    output logic             freeze,
    output logic             fault_seen
);
    logic     rise;
    verdict_t verdict;
    logic     muted;

    lrck_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .lrck_in(lrck_in), .rise(rise)
    );

    lrck_period_check #(.CNT_W(CNT_W), .TOL(TOL)) u_period (
        .clk(clk), .rst_n(rst_n), .rise(rise), .ratio_n(ratio_n),
        .verdict(verdict)
    );

    lrck_fault_ctrl #(.GOOD_RUN(GOOD_RUN)) u_fault (
        .clk(clk), .rst_n(rst_n), .verdict(verdict), .pll_locked(pll_locked),
        .detect_en(detect_en), .status_clr(status_clr), .muted(muted),
        .fault_seen(fault_seen)
    );

    // one state drives both actions
    assign mute   = muted;
    assign freeze = muted;
endmodule

// File: tb/lrck_sync_monitor_test.sv
`timescale 1ns/1ps
module lrck_sync_monitor_test;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lrck_in = 1'b0;
    logic             pll_locked = 1'b1;
    logic             detect_en = 1'b1;
    logic [CNT_W-1:0] ratio_n = 8'd64;
    logic             status_clr = 1'b0;
    logic             mute, freeze, fault_seen;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lrck_sync_monitor #(.CNT_W(CNT_W), .TOL(4), .GOOD_RUN(4), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .lrck_in(lrck_in), .pll_locked(pll_locked),
        .detect_en(detect_en), .ratio_n(ratio_n), .status_clr(status_clr),
        .mute(mute), .freeze(freeze), .fault_seen(fault_seen)
    );

    typedef struct packed {
        logic [7:0] per;
        logic       lock;
        logic       en;
        logic       exp_mute;
    } row_t;

    // expected mute, sampled 6 cycles into each period, reflects the previous periods
    localparam int ROWS = 22;
    localparam row_t VEC [ROWS] = '{
        '{8'd64, 1'b1, 1'b1, 1'b0},  // first edge arms (R2)
        '{8'd64, 1'b1, 1'b1, 1'b0},
        '{8'd60, 1'b1, 1'b1, 1'b0},
        '{8'd68, 1'b1, 1'b1, 1'b0},  // 60 judged in range (R2)
        '{8'd59, 1'b1, 1'b1, 1'b0},  // 68 judged in range (R2)
        '{8'd64, 1'b1, 1'b1, 1'b1},  // 59 out of range (R3)
        '{8'd64, 1'b1, 1'b1, 1'b1},
        '{8'd64, 1'b1, 1'b1, 1'b1},
        '{8'd64, 1'b1, 1'b1, 1'b1},
        '{8'd64, 1'b1, 1'b1, 1'b0},  // fourth good period releases (R6)
        '{8'd69, 1'b1, 1'b1, 1'b0},
        '{8'd64, 1'b1, 1'b1, 1'b1},  // 69 too long (R3 R4)
        '{8'd64, 1'b1, 1'b1, 1'b1},
        '{8'd64, 1'b0, 1'b1, 1'b1},  // lock lost, run restarts (R5 R6)
        '{8'd64, 1'b1, 1'b1, 1'b1},
        '{8'd64, 1'b1, 1'b1, 1'b1},
        '{8'd64, 1'b1, 1'b1, 1'b1},
        '{8'd64, 1'b1, 1'b1, 1'b0},
        '{8'd80, 1'b1, 1'b0, 1'b0},  // disabled: timeout ignored (R7)
        '{8'd64, 1'b1, 1'b0, 1'b0},  // disabled: bad period ignored (R7)
        '{8'd64, 1'b1, 1'b1, 1'b0},
        '{8'd64, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one LRCK period starting with a rising edge; checks 6 cycles in
    task automatic run_period(input row_t r, input int idx);
        lrck_in    = 1'b1;
        pll_locked = r.lock;
        detect_en  = r.en;
        ticks(6);
        check(mute, r.exp_mute, $sformatf("R3/R6 row %0d mute", idx));
        check(freeze, mute, $sformatf("R9 row %0d freeze", idx));
        ticks(int'(r.per) / 2 - 6);
        lrck_in = 1'b0;
        ticks(int'(r.per) - int'(r.per) / 2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ticks(4);
        rst_n = 1'b1;
    endtask

    initial begin
        ticks(1);
        do_reset();
        // R1: reset state
        check(mute, 1'b0, "R1 mute");
        check(freeze, 1'b0, "R1 freeze");
        check(fault_seen, 1'b0, "R1 fault_seen");

        for (int i = 0; i < ROWS; i++) run_period(VEC[i], i);

        // R8: faults were seen, including while disabled
        check(fault_seen, 1'b1, "R8 sticky after table");

        // R4: LRCK stopped from reset; timeout after ratio_n+4 cycles
        lrck_in = 1'b0; pll_locked = 1'b1; detect_en = 1'b1;
        do_reset();
        ticks(50);
        check(mute, 1'b0, "R4 no timeout yet");
        check(fault_seen, 1'b0, "R8 clear before timeout");
        ticks(25);
        check(mute, 1'b1, "R4 timeout mutes");
        check(freeze, 1'b1, "R9 timeout freezes");
        check(fault_seen, 1'b1, "R8 set by timeout");

        // R8: clear with no fault present
        status_clr = 1'b1; ticks(1); status_clr = 1'b0; ticks(1);
        check(fault_seen, 1'b0, "R8 cleared");
        check(mute, 1'b1, "R4 saturated count keeps mute");

        // R8: a fault in the clear cycle wins
        pll_locked = 1'b0; status_clr = 1'b1; ticks(1); status_clr = 1'b0;
        ticks(1);
        check(fault_seen, 1'b1, "R8 fault beats clear");

        // R7: dropping the enable releases at once, even with lock lost
        detect_en = 1'b0; ticks(1);
        check(mute, 1'b0, "R7 enable cleared");
        check(freeze, 1'b0, "R7 freeze released");

        // R5: lock loss with enable set mutes on the next edge
        detect_en = 1'b1; ticks(1);
        check(mute, 1'b1, "R5 lock loss");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule